// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block decodes the single-register memory-transfer class of a 32-bit fixed-width instruction word. From the instruction, the current value of the base register and the current value of the offset register, it forms the address sent to data memory. It also reports whether the access is a load or a store and whether it moves a byte or a word. Finally, it gives the updated base value and a flag saying whether that value must be written back to the register file.

The offset is either a 12-bit unsigned immediate or a register value passed through a barrel shifter. Three instruction bits control how the offset is applied: one chooses whether the offset is applied before or after the access, one chooses whether it is added or subtracted, and one requests base write-back. In the default registered build, every output is captured on the clock edge that follows an `in_valid` pulse and holds its value until the next pulse. With `REGISTERED = 0` the outputs follow the inputs combinationally.

Top module: `lsag_top`

## Requirements
- R1: While `rst` is high, the next clock edge clears `mem_addr`, `wb_value`, `base_sel`, `data_sel`, `is_load`, `is_byte` and `wb_en` to zero.
- R2: When bit 24 (index-before) is 0, `mem_addr` equals the unmodified base value.
- R3: When bit 24 is 1, `mem_addr` is the base plus the offset if bit 23 is 1, and the base minus the offset if bit 23 is 0. The arithmetic wraps modulo 2^32.
- R4: When bit 25 is 0, the offset is bits [11:0] of the instruction, zero-extended.
- R5: When bit 25 is 1, the offset is `ofs_val` shifted by the amount in bits [11:7]. Bits [6:5] select the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R6: A shift amount of 0 means a shift of 32 for logical right (result 0) and for arithmetic right (every bit a copy of bit 31). For logical left and for rotate right, an amount of 0 leaves the value unchanged.
- R7: `is_load` reflects bit 20 (1 load, 0 store). `is_byte` reflects bit 22 (1 byte, 0 word).
- R8: `wb_value` is always the base combined with the offset as in R3. `wb_en` is 1 whenever bit 24 is 0. When bit 24 is 1, `wb_en` equals bit 21.
- R9: In the registered build, outputs change only on the clock edge after a cycle with `in_valid` high, and hold their values otherwise.
- R10: `base_sel` reflects bits [19:16] and `data_sel` reflects bits [15:12].
- R11: Word 0xE56DA004 with base 0x00001000 gives address 0x00000FFC, a byte store, write-back enabled, `base_sel` 13 and `data_sel` 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures the current inputs |
| instr | input | 32 | Transfer instruction word |
| base_val | input | XLEN | Value of the base register |
| ofs_val | input | XLEN | Value of the offset register |
| mem_addr | output | XLEN | Address for the data access |
| is_load | output | 1 | 1 load, 0 store |
| is_byte | output | 1 | 1 byte, 0 word |
| wb_en | output | 1 | Base register write-back enable |
| wb_value | output | XLEN | Updated base value |
| base_sel | output | 4 | Base register number |
| data_sel | output | 4 | Source/destination register number |

## Verification
Directed words exercise each shift type with amounts 0, 1 and 31. The sign-filled arithmetic case with amount 0 tells the "amount 0 means 32" rule apart from "no shift". Random words cover every combination of index-before, add/subtract and write-back, with bases near zero and near 2^32 so that address wrap shows up in both directions. Cycles with `in_valid` low and changing inputs show whether the registered outputs really hold, and the two worked encodings pin down the field positions.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int unsigned IW      = 32;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned IMM_W   = 12;
  localparam int unsigned SAMT_W  = 5;

  // bit positions inside the instruction word
  localparam int unsigned B_REGOFS = 25;
  localparam int unsigned B_PRE    = 24;
  localparam int unsigned B_UP     = 23;
  localparam int unsigned B_BYTE   = 22;
  localparam int unsigned B_WBACK  = 21;
  localparam int unsigned B_LOAD   = 20;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic               reg_ofs;
    logic               pre;
    logic               up;
    logic               byte_sz;
    logic               wback;
    logic               load;
    logic [SEL_W-1:0]   base_sel;
    logic [SEL_W-1:0]   data_sel;
    logic [IMM_W-1:0]   imm;
    logic [SAMT_W-1:0]  amt;
    shift_kind_e        kind;
  } ls_fields_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ls_fields_t    fields
);
  logic unused_bits;
  assign unused_bits = ^{instr[31:26], instr[4], instr[3:0]};

  always_comb begin
    fields.reg_ofs  = instr[B_REGOFS];
    fields.pre      = instr[B_PRE];
    fields.up       = instr[B_UP];
    fields.byte_sz  = instr[B_BYTE];
    fields.wback    = instr[B_WBACK];
    fields.load     = instr[B_LOAD];
    fields.base_sel = instr[19:16];
    fields.data_sel = instr[15:12];
    fields.imm      = instr[11:0];
    fields.amt      = instr[11:7];
    fields.kind     = shift_kind_e'(instr[6:5]);
  end
endmodule

// File: rtl/lsag_shifter.sv
module lsag_shifter
  import lsag_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = SAMT_W
) (
  input  logic [XLEN-1:0] din,
  input  logic [AW-1:0]   amt,
  input  shift_kind_e     kind,
  output logic [XLEN-1:0] dout
);
  localparam int unsigned EW = AW + 1;

  logic [EW-1:0]     eff_amt;
  logic [XLEN-1:0]   lsl_v, lsr_v, asr_v, ror_v;
  logic [2*XLEN-1:0] dbl;

  // a zero amount stands for a full-width shift on the right shifts
  assign eff_amt = (amt == '0) ? EW'(XLEN) : {1'b0, amt};

  assign lsl_v = din << amt;
  assign lsr_v = din >> eff_amt;
  assign asr_v = XLEN'($signed(din) >>> eff_amt);
  assign dbl   = {din, din} >> amt;
  assign ror_v = dbl[XLEN-1:0];

  always_comb begin
    unique case (kind)
      SH_LSL:  dout = lsl_v;
      SH_LSR:  dout = lsr_v;
      SH_ASR:  dout = asr_v;
      default: dout = ror_v;
    endcase
  end

  always_comb begin
    if (kind == SH_ROR && amt == '0)
      a_r6_ror_zero_passes: assert (dout == din);
    if (kind == SH_LSR && amt == '0)
      a_r6_lsr_zero_clears: assert (dout == '0);
    if (kind == SH_ASR && amt == '0)
      a_r6_asr_zero_fills: assert (dout == {XLEN{din[XLEN-1]}});
  end
endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] ofs,
  input  logic            pre,
  input  logic            up,
  input  logic            wback,
  output logic [XLEN-1:0] addr,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val
);
  logic [XLEN-1:0] moved;

  assign moved  = up ? (base + ofs) : (base - ofs);
  assign addr   = pre ? moved : base;
  assign wb_val = moved;
  assign wb_en  = (!pre) || wback;

  always_comb begin
    if (!pre)
      a_r2_post_uses_base: assert (addr == base && wb_en);
    if (pre)
      a_r3_pre_addr_is_update: assert (addr == wb_val);
    if (up)
      a_r3_up_adds: assert (wb_val - ofs == base);
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IW-1:0]    instr,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  ofs_val,
  output logic [XLEN-1:0]  mem_addr,
  output logic             is_load,
  output logic             is_byte,
  output logic             wb_en,
  output logic [XLEN-1:0]  wb_value,
  output logic [SEL_W-1:0] base_sel,
  output logic [SEL_W-1:0] data_sel
);
  ls_fields_t      f;
  logic [XLEN-1:0] imm_ofs, sh_ofs, ofs_sel;
  logic [XLEN-1:0] c_addr, c_wbv;
  logic            c_wben;

  lsag_decode u_dec (.instr(instr), .fields(f));

  lsag_shifter #(.XLEN(XLEN), .AW(SAMT_W)) u_sh (
    .din(ofs_val), .amt(f.amt), .kind(f.kind), .dout(sh_ofs)
  );

  assign imm_ofs = XLEN'(f.imm);
  assign ofs_sel = f.reg_ofs ? sh_ofs : imm_ofs;

  lsag_addr_calc #(.XLEN(XLEN)) u_ac (
    .base(base_val), .ofs(ofs_sel), .pre(f.pre), .up(f.up), .wback(f.wback),
    .addr(c_addr), .wb_en(c_wben), .wb_val(c_wbv)
  );

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          mem_addr <= '0;
          wb_value <= '0;
          wb_en    <= 1'b0;
          is_load  <= 1'b0;
          is_byte  <= 1'b0;
          base_sel <= '0;
          data_sel <= '0;
        end else if (in_valid) begin
          mem_addr <= c_addr;
          wb_value <= c_wbv;
          wb_en    <= c_wben;
          is_load  <= f.load;
          is_byte  <= f.byte_sz;
          base_sel <= f.base_sel;
          data_sel <= f.data_sel;
        end
      end

      a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && wb_value == '0 && !wb_en && !is_load && !is_byte));

      a_r9_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(mem_addr) && $stable(wb_value) && $stable(wb_en)));

      a_r8_post_forces_wb: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(instr[B_PRE])) |-> wb_en);

      a_r7_load_flag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (is_load == $past(instr[B_LOAD])));
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, in_valid};
      assign mem_addr = c_addr;
      assign wb_value = c_wbv;
      assign wb_en    = c_wben;
      assign is_load  = f.load;
      assign is_byte  = f.byte_sz;
      assign base_sel = f.base_sel;
      assign data_sel = f.data_sel;
    end
  endgenerate
endmodule

// File: tb/lsag_top_tb.sv
module lsag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, base_val = '0, ofs_val = '0;
  logic [31:0] mem_addr, wb_value;
  logic        is_load, is_byte, wb_en;
  logic [3:0]  base_sel, data_sel;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit started = 0;

  always #5 clk = ~clk;

  lsag_top #(.XLEN(32), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .base_val(base_val), .ofs_val(ofs_val), .mem_addr(mem_addr),
    .is_load(is_load), .is_byte(is_byte), .wb_en(wb_en),
    .wb_value(wb_value), .base_sel(base_sel), .data_sel(data_sel)
  );

  // expected state of the reference model
  logic [31:0] e_addr = '0, e_wbv = '0;
  logic        e_ld = 0, e_by = 0, e_wb = 0, e_pre = 0;
  logic [3:0]  e_bs = '0, e_ds = '0;

  function automatic logic [31:0] ref_offset(logic [31:0] ins, logic [31:0] rv);
    int n;
    logic [31:0] r;
    if (!ins[25]) return {20'd0, ins[11:0]};          // R4
    n = int'(ins[11:7]);
    r = rv;
    case (ins[6:5])                                  // R5, R6
      2'b00: r = rv << n;
      2'b01: begin if (n == 0) n = 32; for (int k = 0; k < n; k++) r = {1'b0, r[31:1]}; end
      2'b10: begin if (n == 0) n = 32; for (int k = 0; k < n; k++) r = {r[31], r[31:1]}; end
      default: for (int k = 0; k < n; k++) r = {r[0], r[31:1]};
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      e_addr <= '0; e_wbv <= '0; e_ld <= 0; e_by <= 0; e_wb <= 0; e_bs <= '0; e_ds <= '0; e_pre <= 0;
    end else if (in_valid) begin : upd
      logic [31:0] o, moved;
      o = ref_offset(instr, ofs_val);
      moved = instr[23] ? base_val + o : base_val - o;
      e_wbv <= moved;
      e_addr <= instr[24] ? moved : base_val;
      e_wb  <= !instr[24] ? 1'b1 : instr[21];
      e_ld  <= instr[20];
      e_by  <= instr[22];
      e_bs  <= instr[19:16];
      e_ds  <= instr[15:12];
      e_pre <= instr[24];
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every clock: outputs against the model (R9 hold is covered since the model only moves on in_valid)
  always @(negedge clk) begin
    if (started) begin
      chk(e_pre ? "R3" : "R2", "mem_addr", mem_addr, e_addr);
      chk("R8", "wb_value", wb_value, e_wbv);
      chk("R8", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
      chk("R7", "is_load", {31'd0, is_load}, {31'd0, e_ld});
      chk("R7", "is_byte", {31'd0, is_byte}, {31'd0, e_by});
      chk("R10", "base_sel", {28'd0, base_sel}, {28'd0, e_bs});
      chk("R10", "data_sel", {28'd0, data_sel}, {28'd0, e_ds});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic drive(logic [31:0] ins, logic [31:0] b, logic [31:0] o);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; base_val = b; ofs_val = o;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] regform(logic [1:0] kind, logic [4:0] amt, logic pre, logic up);
    return {4'hE, 2'b01, 1'b1, pre, up, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, amt, kind, 1'b0, 4'd7};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "mem_addr", mem_addr, 32'h0);
    chk("R1", "flags", {29'd0, is_load, is_byte, wb_en}, 32'h0);
    rst = 1'b0;

    // R11: worked encodings
    drive(32'hE56DA004, 32'h0000_1000, 32'h0);
    @(negedge clk);
    chk("R11", "mem_addr", mem_addr, 32'h0000_0FFC);
    chk("R11", "ld/by/wb", {29'd0, is_load, is_byte, wb_en}, 32'b011);
    chk("R11", "sels", {24'd0, base_sel, data_sel}, 32'hDA);
    drive(32'hE59D8000, 32'h0000_2000, 32'h0);
    @(negedge clk);
    chk("R11", "load addr", mem_addr, 32'h0000_2000);
    chk("R11", "ld/by/wb", {29'd0, is_load, is_byte, wb_en}, 32'b100);

    // R5/R6: each shift kind with amounts 0, 1, 31 on a negative value
    for (int kd = 0; kd < 4; kd++) begin
      drive(regform(2'(kd), 5'd0, 1'b1, 1'b1), 32'h0000_0100, 32'h8000_00F1);
      drive(regform(2'(kd), 5'd1, 1'b1, 1'b0), 32'h0000_0100, 32'h8000_00F1);
      drive(regform(2'(kd), 5'd31, 1'b0, 1'b1), 32'hFFFF_FFF0, 32'h8000_00F1);
    end
    // R6 directed: arithmetic right by "0" (=32) of a negative value gives all ones, added to base
    drive(regform(2'b10, 5'd0, 1'b1, 1'b1), 32'h0000_0010, 32'h8000_0000);
    @(negedge clk);
    chk("R6", "asr32 addr", mem_addr, 32'h0000_000F);

    // R9: inputs change with in_valid low; outputs must hold
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      instr = $urandom; base_val = $urandom; ofs_val = $urandom;
    end

    // R2/R3/R4/R8: random words incl. wrap around zero and 2^32
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins, b;
      ins = $urandom;
      ins[27:26] = 2'b01;
      b = (i % 3 == 0) ? (32'hFFFF_FFF8 + (i % 16)) : (i % 3 == 1) ? 32'(i % 16) : $urandom;
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      instr = ins; base_val = b; ofs_val = $urandom;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule